// File: doc/BRIEF.md
# Pin Multiplexing and Change-Interrupt I/O Controller

This block sits between a bank of bidirectional pads and the on-chip peripherals that share them. Each pin is owned either by the controller itself, acting as general-purpose I/O, or by a peripheral. Under controller ownership, software sets the pad's drive enable and output level. Under peripheral ownership, the peripheral's own output and enable reach the pad unchanged. Every pad input is passed to the peripheral side at all times. The synchronized pad level can be read back over the register bus.

Every programmable bit vector is changed through a pair of write-only addresses. Writing a 1 to the "raise" address sets the matching bit. Writing a 1 to the "lower" address clears it. Bits written as 0 are left alone, so no read-modify-write is needed. A third address reads the current vector.

The controller also watches the synchronized level of every pin and records each transition, rising or falling, in a sticky change vector. Reading that vector clears it. A per-pin mask decides which recorded changes drive the single interrupt output.

Top module: `pin_io_ctrl`

## Requirements
- R1: After a cycle with `rst` high, every pin is owned by the controller (ownership vector all ones), and the drive-enable, output-level, mask and change vectors are all zero, so `pad_oe` and `irq` are 0.
- R2: A write to a raise address sets exactly the bits that are 1 in `bus_wdata`, from the next cycle on, and leaves all other bits as they were. The raise addresses are 0 (ownership), 3 (drive enable), 6 (output level) and 9 (mask).
- R3: A write to a lower address clears exactly the bits that are 1 in `bus_wdata`, from the next cycle on, and leaves all other bits as they were. The lower addresses are 1 (ownership), 4 (drive enable), 7 (output level) and 10 (mask).
- R4: In the same cycle, a pin whose ownership bit is 1 drives `pad_out`/`pad_oe` from its output-level/drive-enable bits. A pin whose ownership bit is 0 drives them from `periph_out`/`periph_oe`.
- R5: While `bus_rd` is high, `bus_rdata` shows in the same cycle the vector named by `bus_addr`: 2 ownership, 5 drive enable, 8 output level, 11 mask, 12 pin level, 13 change status. Bit i always belongs to pin i.
- R6: The pin level read at address 12 is `pad_in` delayed through two register stages, so it shows a pad change after the second rising edge.
- R7: A level change of either polarity on pin i sets change bit i after the third rising edge that follows the pad change. This does not depend on the mask or on ownership.
- R8: A change bit stays set until a read at address 13. That read returns the bits and clears them at the clock edge ending the read, except that a change detected at that same edge stays set.
- R9: `irq` is 1 exactly when some pin has both its change bit and its mask bit set. It follows the registers in the same cycle.
- R10: `periph_in` equals `pad_in` for every pin, whatever the ownership.
- R11: Writes to addresses 2, 5, 8, 11, 12, 13, 14 and 15 change no state. Reads from addresses 0, 1, 3, 4, 6, 7, 9, 10, 14 and 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe; a read at address 13 clears the change vector |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | NUM_PINS | Write data, bit i for pin i |
| bus_rdata | output | NUM_PINS | Read data, valid in the strobe cycle |
| pad_in | input | NUM_PINS | Levels seen at the pads |
| pad_out | output | NUM_PINS | Level driven to the pads |
| pad_oe | output | NUM_PINS | Pad drive enable, 1 drives |
| periph_out | input | NUM_PINS | Peripheral output levels |
| periph_oe | input | NUM_PINS | Peripheral drive enables |
| periph_in | output | NUM_PINS | Pad levels forwarded to the peripherals |
| irq | output | 1 | Level interrupt request |

## Verification
Some results follow their cause in the same cycle: pad outputs after an ownership or peripheral change, the interrupt after a mask or status change, and read data for a strobed address. Written vectors appear one edge after the write. The level readback shows a pad change after two edges, and the change bit after three. The reference model in the bench steps its own two-stage pipeline and previous-sample register on the same edge as the design. Outputs are compared at the falling edge, before new inputs are driven, so every expected value comes from the model state updated at the last rising edge. Back-to-back change-status reads while pins toggle cover the case where a clear and a new detection fall on the same edge.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;

    localparam int PIN_COUNT = 32;
    localparam int ADDR_W    = 4;
    localparam int NUM_GRP   = 4;

    // Register groups: each occupies three consecutive word addresses
    // (raise, lower, status) starting at GRP * 3.
    localparam int GRP_OWN = 0;
    localparam int GRP_OE  = 1;
    localparam int GRP_OUT = 2;
    localparam int GRP_MSK = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_OWN_SET  = 4'd0,
        RA_OWN_CLR  = 4'd1,
        RA_OWN_STAT = 4'd2,
        RA_OE_SET   = 4'd3,
        RA_OE_CLR   = 4'd4,
        RA_OE_STAT  = 4'd5,
        RA_OUT_SET  = 4'd6,
        RA_OUT_CLR  = 4'd7,
        RA_OUT_STAT = 4'd8,
        RA_MSK_SET  = 4'd9,
        RA_MSK_CLR  = 4'd10,
        RA_MSK_STAT = 4'd11,
        RA_LEVEL    = 4'd12,
        RA_CHG      = 4'd13
    } reg_addr_e;

    typedef struct packed {
        logic raise;
        logic lower;
    } setclr_t;

    function automatic setclr_t decode_setclr(input logic wr,
                                              input logic [ADDR_W-1:0] addr,
                                              input int grp);
        setclr_t s;
        s.raise = wr && (addr == ADDR_W'(grp * 3));
        s.lower = wr && (addr == ADDR_W'(grp * 3 + 1));
        return s;
    endfunction

endpackage

// File: rtl/pin_io_setclr.sv
module pin_io_setclr #(
    parameter int             W       = 32,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  pin_io_pkg::setclr_t      cmd,
    input  logic [W-1:0]             wdata,
    output logic [W-1:0]             q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (cmd.raise) begin
            q <= q | wdata;
        end else if (cmd.lower) begin
            q <= q & ~wdata;
        end
    end
endmodule

// File: rtl/pin_io_sync.sv
module pin_io_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_in,
    input  logic         rd_clear,
    output logic [W-1:0] level_q,
    output logic [W-1:0] prev_q,
    output logic [W-1:0] chg_q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] edge_now;

    assign edge_now = level_q ^ prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= '0;
            level_q <= '0;
            prev_q  <= '0;
            chg_q   <= '0;
        end else begin
            meta_q  <= pad_in;
            level_q <= meta_q;
            prev_q  <= level_q;
            // new detections win over a same-edge read clear
            chg_q   <= (rd_clear ? '0 : chg_q) | edge_now;
        end
    end
endmodule

// File: rtl/pin_io_mux.sv
module pin_io_mux #(
    parameter int W = 32
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] gp_out,
    input  logic [W-1:0] gp_oe,
    input  logic [W-1:0] periph_out,
    input  logic [W-1:0] periph_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign pad_out[i] = own[i] ? gp_out[i] : periph_out[i];
        assign pad_oe[i]  = own[i] ? gp_oe[i]  : periph_oe[i];
    end
endmodule

// File: rtl/pin_io_ctrl.sv
module pin_io_ctrl
    import pin_io_pkg::*;
#(
    parameter int NUM_PINS = PIN_COUNT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    input  logic [NUM_PINS-1:0] periph_out,
    input  logic [NUM_PINS-1:0] periph_oe,
    output logic [NUM_PINS-1:0] periph_in,
    output logic                irq
);
    localparam logic [NUM_PINS-1:0] ALL_ONES = {NUM_PINS{1'b1}};

    logic [NUM_PINS-1:0] grp_q [NUM_GRP];
    logic [NUM_PINS-1:0] own_q, oe_q, out_q, mask_q;
    logic [NUM_PINS-1:0] level_q, prev_q, chg_q;
    logic                rd_clear;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        setclr_t cmd;
        assign cmd = decode_setclr(bus_wr, bus_addr, g);
        pin_io_setclr #(
            .W       (NUM_PINS),
            .RST_VAL ((g == GRP_OWN) ? ALL_ONES : '0)
        ) u_vec (
            .clk   (clk),
            .rst   (rst),
            .cmd   (cmd),
            .wdata (bus_wdata),
            .q     (grp_q[g])
        );
    end

    assign own_q  = grp_q[GRP_OWN];
    assign oe_q   = grp_q[GRP_OE];
    assign out_q  = grp_q[GRP_OUT];
    assign mask_q = grp_q[GRP_MSK];

    assign rd_clear = bus_rd && (bus_addr == RA_CHG);

    pin_io_sync #(.W(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pad_in   (pad_in),
        .rd_clear (rd_clear),
        .level_q  (level_q),
        .prev_q   (prev_q),
        .chg_q    (chg_q)
    );

    pin_io_mux #(.W(NUM_PINS)) u_mux (
        .own        (own_q),
        .gp_out     (out_q),
        .gp_oe      (oe_q),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    assign periph_in = pad_in;
    assign irq       = |(chg_q & mask_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                RA_OWN_STAT: bus_rdata = own_q;
                RA_OE_STAT:  bus_rdata = oe_q;
                RA_OUT_STAT: bus_rdata = out_q;
                RA_MSK_STAT: bus_rdata = mask_q;
                RA_LEVEL:    bus_rdata = level_q;
                RA_CHG:      bus_rdata = chg_q;
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pin_io_ctrl_chk.sv
module pin_io_ctrl_chk
    import pin_io_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_oe,
    input logic [W-1:0]      periph_out,
    input logic              irq,
    input logic [W-1:0]      own_q,
    input logic [W-1:0]      oe_q,
    input logic [W-1:0]      out_q,
    input logic [W-1:0]      mask_q,
    input logic [W-1:0]      level_q,
    input logic [W-1:0]      prev_q,
    input logic [W-1:0]      chg_q
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (own_q == {W{1'b1}} && pad_oe == '0 && !irq && chg_q == '0));

    assert_raise_only_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_OE_SET) |=>
            (((oe_q & $past(bus_wdata)) == $past(bus_wdata)) &&
             ((oe_q & ~$past(bus_wdata)) == ($past(oe_q) & ~$past(bus_wdata)))));

    assert_lower_only_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_OUT_CLR) |=>
            (((out_q & $past(bus_wdata)) == '0) &&
             ((out_q & ~$past(bus_wdata)) == ($past(out_q) & ~$past(bus_wdata)))));

    assert_owner_mux_R4: assert property (@(posedge clk) disable iff (rst)
        (((pad_out ^ periph_out) & ~own_q) == '0) && (((pad_oe ^ oe_q) & own_q) == '0));

    assert_change_set_R7: assert property (@(posedge clk) disable iff (rst)
        (level_q != prev_q) |=>
            ((chg_q & $past(level_q ^ prev_q)) == $past(level_q ^ prev_q)));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_addr == RA_CHG) |=> (($past(chg_q) & ~chg_q) == '0));

    assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
        irq == ((chg_q & mask_q) != '0));
endmodule

bind pin_io_ctrl pin_io_ctrl_chk #(.W(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .periph_out (periph_out),
    .irq        (irq),
    .own_q      (own_q),
    .oe_q       (oe_q),
    .out_q      (out_q),
    .mask_q     (mask_q),
    .level_q    (level_q),
    .prev_q     (prev_q),
    .chg_q      (chg_q)
);

// File: tb/pin_io_ctrl_tb.sv
`timescale 1ns/1ps
module pin_io_ctrl_tb;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe;
    logic [N-1:0]  periph_out = '0;
    logic [N-1:0]  periph_oe = '0;
    logic [N-1:0]  periph_in;
    logic          irq;

    always #2 clk = ~clk;

    pin_io_ctrl #(.NUM_PINS(N)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .periph_out(periph_out), .periph_oe(periph_oe),
        .periph_in(periph_in), .irq(irq)
    );

    // behavioural reference state
    logic [N-1:0] m_own, m_oe, m_out, m_msk, m_s1, m_s2, m_prev, m_chg;
    int    vectors = 0;
    int    misses  = 0;
    int    cycles  = 0;
    string tag     = "R1";
    bit    done    = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_own <= '1; m_oe <= '0; m_out <= '0; m_msk <= '0;
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_chg <= '0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    4'd0:  m_own <= m_own | bus_wdata;
                    4'd1:  m_own <= m_own & ~bus_wdata;
                    4'd3:  m_oe  <= m_oe  | bus_wdata;
                    4'd4:  m_oe  <= m_oe  & ~bus_wdata;
                    4'd6:  m_out <= m_out | bus_wdata;
                    4'd7:  m_out <= m_out & ~bus_wdata;
                    4'd9:  m_msk <= m_msk | bus_wdata;
                    4'd10: m_msk <= m_msk & ~bus_wdata;
                    default: ;
                endcase
            end
            m_s1   <= pad_in;
            m_s2   <= m_s1;
            m_prev <= m_s2;
            m_chg  <= ((bus_rd && bus_addr == 4'd13) ? '0 : m_chg) | (m_s2 ^ m_prev);
        end
    end

    function automatic logic [N-1:0] ref_read(input logic [3:0] a);
        case (a)
            4'd2:  return m_own;
            4'd5:  return m_oe;
            4'd8:  return m_out;
            4'd11: return m_msk;
            4'd12: return m_s2;
            4'd13: return m_chg;
            default: return '0;
        endcase
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare every cycle at the falling edge, before new inputs are driven
    always @(negedge clk) begin
        if (!done) begin
            cycles++;
            cmp("R4", "pad_out", pad_out, (m_own & m_out) | (~m_own & periph_out));
            cmp("R4", "pad_oe",  pad_oe,  (m_own & m_oe)  | (~m_own & periph_oe));
            cmp("R9", "irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_chg & m_msk)});
            cmp("R10", "periph_in", periph_in, pad_in);
            if (bus_rd) cmp(tag, $sformatf("rdata@%0d", bus_addr), bus_rdata, ref_read(bus_addr));
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > 20000) begin
                misses++;
                $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        idle(3);
        #0 rst = 1'b0;
        // R1: reset values through status reads
        tag = "R1";
        rd(4'd2); rd(4'd5); rd(4'd8); rd(4'd11); rd(4'd13); rd(4'd12);
        // R2: raise addresses
        tag = "R2";
        wr(4'd3, 32'hA5A5_0F0F); rd(4'd5);
        wr(4'd3, 32'h0000_00F0); rd(4'd5);
        wr(4'd6, 32'h1234_5678); rd(4'd8);
        wr(4'd9, 32'hFFFF_0000); rd(4'd11);
        // R3: lower addresses
        tag = "R3";
        wr(4'd4, 32'h0000_000F); rd(4'd5);
        wr(4'd7, 32'h0000_0078); rd(4'd8);
        wr(4'd1, 32'h0000_FF00); rd(4'd2);
        wr(4'd10, 32'h0F00_0000); rd(4'd11);
        // R4: ownership multiplexing with peripheral patterns
        tag = "R4";
        step(); periph_out = 32'hFFFF_FFFF; periph_oe = 32'h0000_FF00; idle(2);
        periph_out = 32'h5555_AAAA; periph_oe = 32'hFFFF_FFFF; idle(2);
        wr(4'd0, 32'h0000_0F00); idle(2);
        wr(4'd1, 32'hF000_000F); idle(2);
        // R5, R6: level readback pipeline
        tag = "R6";
        step(); pad_in = 32'hDEAD_BEEF;
        rd(4'd12); rd(4'd12); rd(4'd12); rd(4'd12);
        // R7, R8: change capture and clear-on-read
        tag = "R7";
        rd(4'd13); rd(4'd13);
        step(); pad_in[0] = 1'b0; pad_in[31] = 1'b0;
        rd(4'd13); rd(4'd13); rd(4'd13); rd(4'd13); rd(4'd13);
        tag = "R8";
        step(); pad_in[4] = ~pad_in[4];
        idle(1);
        rd(4'd13);          // read in the same cycle the change lands
        rd(4'd13); rd(4'd13);
        step(); pad_in[20] = ~pad_in[20]; idle(6); rd(4'd13); rd(4'd13);
        // R9: mask gates the interrupt
        tag = "R9";
        step(); pad_in[16] = ~pad_in[16]; pad_in[3] = ~pad_in[3]; idle(5);
        wr(4'd10, 32'hFFFF_FFFF); idle(2);
        wr(4'd9, 32'h0000_0008); idle(2);
        wr(4'd10, 32'h0000_0008); wr(4'd9, 32'h0001_0000); idle(2);
        rd(4'd13); idle(2);
        // R11: read-only and unmapped addresses
        tag = "R11";
        wr(4'd2, '1); wr(4'd5, '1); wr(4'd8, '1); wr(4'd11, '1);
        wr(4'd12, '1); wr(4'd13, '1); wr(4'd14, '1); wr(4'd15, '1);
        rd(4'd2); rd(4'd5); rd(4'd8); rd(4'd11); rd(4'd13);
        rd(4'd0); rd(4'd1); rd(4'd3); rd(4'd4); rd(4'd6); rd(4'd7);
        rd(4'd9); rd(4'd10); rd(4'd14); rd(4'd15);
        // mixed traffic
        tag = "R5";
        for (int k = 0; k < 400; k++) begin
            int op;
            op = $urandom_range(0, 3);
            if (k % 7 == 0) pad_in = pad_in ^ (32'h1 << $urandom_range(0, 31));
            if (k % 11 == 0) periph_out = $urandom;
            if (op == 0) wr(4'($urandom_range(0, 15)), $urandom);
            else if (op == 1) rd(4'($urandom_range(0, 15)));
            else step();
        end
        // reset mid-run
        tag = "R1";
        step(); rst = 1'b1; idle(2); rst = 1'b0; pad_in = '0;
        rd(4'd2); rd(4'd5); rd(4'd8); rd(4'd11); idle(4); rd(4'd13);
        idle(2);
        finish_run();
    end
endmodule